// File: doc/BRIEF.md
# RV32I Instruction Classifier with Halt Capture

This block sorts a 32-bit base-integer instruction word into one of ten execution classes and stops the pipeline as soon as an encoding arrives that the core does not support. Classification is purely combinational: the class vector and a cause code follow the instruction input in the same cycle. Each instruction also comes with its program counter and a valid strobe. When a valid instruction is illegal, a registered capture stage sets a sticky halt flag and latches the PC, the instruction word and the cause. It also raises a stall output so that fetch stops advancing.

Ordering barriers retire as no-ops because the core has no caches. Instruction-stream synchronisation gets its own decode policy and halts. Environment calls, breakpoints, CSR accesses and every other system encoding halt too, each with its own cause, so none of them can slip through silently. Only a synchronous reset clears the halt.

Top module: `rv32i_decode_guard`

## Requirements
- R1: For a legal instruction, `dec_class` is one-hot and `dec_cause` is 0. The bits are: 0 register ALU (opcode 0110011), 1 immediate ALU (0010011), 2 load (0000011), 3 store (0100011), 4 branch (1100011), 5 JAL (1101111), 6 JALR (1100111), 7 LUI (0110111), 8 AUIPC (0010111) and 9 no-op.
- R2: On register-ALU words, funct7 must be 0000000, or 0100000 when funct3 is 000 or 101. On shift-immediate words (funct3 001), funct7 must be 0000000, and on funct3 101 it may also be 0100000. Any other funct7 value is illegal with cause 5.
- R3: A MISC-MEM word with funct3 000 (fence) sets class bit 9, has cause 0 and never halts.
- R4: A MISC-MEM word with funct3 001 (fence.i) is illegal with cause 3.
- R5: The word 0x00000073 (ecall) is illegal with cause 1, and the word 0x00100073 (ebreak) is illegal with cause 2. Neither sets the no-op bit.
- R6: Any other SYSTEM-opcode (1110011) word, including CSR accesses, is illegal with cause 4.
- R7: The following are illegal with cause 5 and give an all-zero `dec_class`: a word whose low two bits are not 11, an unknown opcode, and a funct3 that the base set does not define for load, store, branch, JALR or MISC-MEM.
- R8: When `in_valid` is high with an illegal word, `halt` is set at the next rising clock edge. At that edge `halt_pc`, `halt_instr` and `halt_cause` take that instruction's PC, word and cause.
- R9: Once set, the halt flag and the captured PC, word and cause do not change until reset, whatever instructions arrive afterwards.
- R10: `stall` equals `halt` in every cycle.
- R11: An illegal word presented with `in_valid` low never sets `halt`, and neither does a legal word presented with `in_valid` high.
- R12: A synchronous reset (`rst` high at a rising edge) clears `halt`, `stall` and all captured fields to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and PC are valid this cycle |
| in_pc | input | 32 | PC of the presented instruction |
| in_instr | input | 32 | Instruction word |
| dec_class | output | 10 | One-hot decoded class, zero when illegal |
| dec_cause | output | 3 | 0 legal, 1 ecall, 2 ebreak, 3 fence.i, 4 other SYSTEM, 5 other illegal |
| halt | output | 1 | Sticky halt flag |
| stall | output | 1 | Fetch-hold request, mirrors halt |
| halt_pc | output | 32 | Captured PC of the offending instruction |
| halt_instr | output | 32 | Captured offending instruction word |
| halt_cause | output | 3 | Captured cause code |

## Verification
The class vector and the cause code have no register in their path, so they are due in the cycle the word is driven. The bench drives each word at a falling edge and samples it one time unit later, before any rising edge. The halt flag, the stall and the captured fields pass through exactly one register, so they are due just after the first rising edge that sees the valid illegal word. The bench samples them one time unit after that edge. It also holds later words across several more edges to show that the captured values stay frozen.

// File: rtl/rvd_pkg.sv
package rvd_pkg;
  localparam int ILEN   = 32;
  localparam int NCLS   = 10;
  localparam int CAUSEW = 3;

  localparam int CLS_ALUR  = 0;
  localparam int CLS_ALUI  = 1;
  localparam int CLS_LOAD  = 2;
  localparam int CLS_STORE = 3;
  localparam int CLS_BR    = 4;
  localparam int CLS_JAL   = 5;
  localparam int CLS_JALR  = 6;
  localparam int CLS_LUI   = 7;
  localparam int CLS_AUIPC = 8;
  localparam int CLS_NOP   = 9;

  typedef logic [CAUSEW-1:0] cause_t;
  localparam cause_t CZ_NONE   = 3'd0;
  localparam cause_t CZ_ECALL  = 3'd1;
  localparam cause_t CZ_EBREAK = 3'd2;
  localparam cause_t CZ_FENCEI = 3'd3;
  localparam cause_t CZ_SYS    = 3'd4;
  localparam cause_t CZ_OTHER  = 3'd5;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_MISC   = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [ILEN-1:0] W_ECALL  = 32'h0000_0073;
  localparam logic [ILEN-1:0] W_EBREAK = 32'h0010_0073;

  // Class vector: checks legality per opcode and sets one bit.
  function automatic logic [NCLS-1:0] class_of(input logic [ILEN-1:0] w);
    logic [NCLS-1:0] c;
    logic [2:0] f3;
    logic [6:0] f7;
    c  = '0;
    f3 = w[14:12];
    f7 = w[31:25];
    unique case (w[6:0])
      OPC_OP:     c[CLS_ALUR]  = (f7 == 7'h00) || ((f7 == 7'h20) && (f3 == 3'd0 || f3 == 3'd5));
      OPC_OPIMM:  c[CLS_ALUI]  = (f3 == 3'd1) ? (f7 == 7'h00) :
                                 (f3 == 3'd5) ? (f7 == 7'h00 || f7 == 7'h20) : 1'b1;
      OPC_LOAD:   c[CLS_LOAD]  = (f3 != 3'd3) && (f3 != 3'd6) && (f3 != 3'd7);
      OPC_STORE:  c[CLS_STORE] = (f3 <= 3'd2);
      OPC_BRANCH: c[CLS_BR]    = (f3[2:1] != 2'b01);
      OPC_JAL:    c[CLS_JAL]   = 1'b1;
      OPC_JALR:   c[CLS_JALR]  = (f3 == 3'd0);
      OPC_LUI:    c[CLS_LUI]   = 1'b1;
      OPC_AUIPC:  c[CLS_AUIPC] = 1'b1;
      OPC_MISC:   c[CLS_NOP]   = (f3 == 3'd0);
      default:    c = '0;
    endcase
    return c;
  endfunction

  // Cause code: written independently of class_of so each cross-checks the other.
  function automatic cause_t cause_of(input logic [ILEN-1:0] w);
    logic [2:0] f3;
    logic [6:0] f7;
    logic ok;
    f3 = w[14:12];
    f7 = w[31:25];
    if (w[1:0] != 2'b11) return CZ_OTHER;
    case (w[6:0])
      OPC_OP: begin
        ok = (f7 == 7'h00) || (f7 == 7'h20 && (f3 == 3'b000 || f3 == 3'b101));
        return ok ? CZ_NONE : CZ_OTHER;
      end
      OPC_OPIMM: begin
        if (f3 == 3'b001)      ok = (f7 == 7'h00);
        else if (f3 == 3'b101) ok = (f7 == 7'h00) || (f7 == 7'h20);
        else                   ok = 1'b1;
        return ok ? CZ_NONE : CZ_OTHER;
      end
      OPC_LOAD:   return (f3 inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5}) ? CZ_NONE : CZ_OTHER;
      OPC_STORE:  return (f3 inside {3'd0, 3'd1, 3'd2}) ? CZ_NONE : CZ_OTHER;
      OPC_BRANCH: return (f3 inside {3'd2, 3'd3}) ? CZ_OTHER : CZ_NONE;
      OPC_JALR:   return (f3 == 3'd0) ? CZ_NONE : CZ_OTHER;
      OPC_JAL, OPC_LUI, OPC_AUIPC: return CZ_NONE;
      OPC_MISC: begin
        if (f3 == 3'd0) return CZ_NONE;
        if (f3 == 3'd1) return CZ_FENCEI;
        return CZ_OTHER;
      end
      OPC_SYSTEM: begin
        if (w == W_ECALL)  return CZ_ECALL;
        if (w == W_EBREAK) return CZ_EBREAK;
        return CZ_SYS;
      end
      default: return CZ_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/rvd_classify.sv
module rvd_classify
  import rvd_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output logic [NCLS-1:0] cls,
  output cause_t          cause,
  output logic            illegal
);
  logic [NCLS-1:0] cls_raw;

  // Compressed or non-32-bit words never reach an opcode class.
  always_comb begin
    cls_raw = (instr[1:0] == 2'b11) ? class_of(instr) : '0;
    cause   = cause_of(instr);
    cls     = cls_raw;
    illegal = (cause != CZ_NONE);
  end

  always_comb begin
    if (!$isunknown(instr)) begin
      p_onehot_r1: assert ($onehot0(cls))
        else $error("class vector not one-hot");
      p_excl_r7: assert ((cls == '0) == illegal)
        else $error("class and cause disagree on legality");
      p_noop_r5: assert (!(cls[CLS_NOP] && (instr == W_ECALL || instr == W_EBREAK)))
        else $error("ecall/ebreak retired as no-op");
    end
  end
endmodule

// File: rtl/rvd_halt_capture.sv
module rvd_halt_capture
  import rvd_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int IW   = ILEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [PC_W-1:0] pc,
  input  logic [IW-1:0]   instr,
  input  cause_t          cause,
  output logic            halt,
  output logic [PC_W-1:0] halt_pc,
  output logic [IW-1:0]   halt_instr,
  output cause_t          halt_cause
);
  logic capture_evt;
  assign capture_evt = fire && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt       <= 1'b0;
      halt_pc    <= '0;
      halt_instr <= '0;
      halt_cause <= CZ_NONE;
    end else if (capture_evt) begin
      halt       <= 1'b1;
      halt_pc    <= pc;
      halt_instr <= instr;
      halt_cause <= cause;
    end
  end

  p_capture_r8: assert property (@(posedge clk) disable iff (rst)
    capture_evt |=> halt && halt_pc == $past(pc) && halt_instr == $past(instr)
                    && halt_cause == $past(cause))
    else $error("capture mismatch");

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt && $stable(halt_pc) && $stable(halt_instr) && $stable(halt_cause))
    else $error("halt state changed while halted");

  p_cause_r8: assert property (@(posedge clk) disable iff (rst)
    halt |-> halt_cause != CZ_NONE)
    else $error("halted with empty cause");
endmodule

// File: rtl/rv32i_decode_guard.sv
module rv32i_decode_guard
  import rvd_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [ILEN-1:0]   in_instr,
  output logic [NCLS-1:0]   dec_class,
  output logic [CAUSEW-1:0] dec_cause,
  output logic              halt,
  output logic              stall,
  output logic [PC_W-1:0]   halt_pc,
  output logic [ILEN-1:0]   halt_instr,
  output logic [CAUSEW-1:0] halt_cause
);
  logic   illegal_now;
  logic   halt_fire;
  cause_t cause_now;
  cause_t cause_held;

  rvd_classify u_cls (
    .instr   (in_instr),
    .cls     (dec_class),
    .cause   (cause_now),
    .illegal (illegal_now)
  );

  assign halt_fire = in_valid && illegal_now;

  rvd_halt_capture #(.PC_W(PC_W), .IW(ILEN)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .fire       (halt_fire),
    .pc         (in_pc),
    .instr      (in_instr),
    .cause      (cause_now),
    .halt       (halt),
    .halt_pc    (halt_pc),
    .halt_instr (halt_instr),
    .halt_cause (cause_held)
  );

  assign dec_cause  = cause_now;
  assign halt_cause = cause_held;
  assign stall      = halt;

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !halt && !halt_fire |=> !halt)
    else $error("halt set without a valid illegal word");

  p_reset_r12: assert property (@(posedge clk)
    rst |=> !halt && !stall && halt_pc == '0 && halt_instr == '0)
    else $error("reset did not clear capture");
endmodule

// File: tb/rv32i_decode_guard_tb.sv
module rv32i_decode_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_pc = '0;
  logic [31:0] in_instr = 32'h0000_0013;
  logic [9:0]  dec_class;
  logic [2:0]  dec_cause;
  logic        halt, stall;
  logic [31:0] halt_pc, halt_instr;
  logic [2:0]  halt_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rv32i_decode_guard u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pc(in_pc), .in_instr(in_instr),
    .dec_class(dec_class), .dec_cause(dec_cause), .halt(halt), .stall(stall),
    .halt_pc(halt_pc), .halt_instr(halt_instr), .halt_cause(halt_cause)
  );

  // {word, expected class, expected cause}; entries 0..12 exercise R2 field rules
  localparam int NV = 43;
  localparam logic [44:0] VEC [NV] = '{
    {32'h003100B3, 10'h001, 3'd0}, // add
    {32'h403100B3, 10'h001, 3'd0}, // sub
    {32'h403150B3, 10'h001, 3'd0}, // sra
    {32'h003120B3, 10'h001, 3'd0}, // slt
    {32'h023100B3, 10'h000, 3'd5}, // funct7 0000001
    {32'h403110B3, 10'h000, 3'd5}, // bit30 with sll
    {32'h00510093, 10'h002, 3'd0}, // addi
    {32'h00311093, 10'h002, 3'd0}, // slli
    {32'h00315093, 10'h002, 3'd0}, // srli
    {32'h40315093, 10'h002, 3'd0}, // srai
    {32'h40311093, 10'h000, 3'd5}, // slli bit30
    {32'h02315093, 10'h000, 3'd5}, // srli bad funct7
    {32'hFFF17093, 10'h002, 3'd0}, // andi negative imm
    {32'h00012083, 10'h004, 3'd0}, // lw
    {32'h00010083, 10'h004, 3'd0}, // lb
    {32'h00014083, 10'h004, 3'd0}, // lbu
    {32'h00015083, 10'h004, 3'd0}, // lhu
    {32'h00013083, 10'h000, 3'd5}, // f3 011 load
    {32'h00016083, 10'h000, 3'd5}, // f3 110 load
    {32'h00312023, 10'h008, 3'd0}, // sw
    {32'h00310023, 10'h008, 3'd0}, // sb
    {32'h00313023, 10'h000, 3'd5}, // f3 011 store
    {32'h00310063, 10'h010, 3'd0}, // beq
    {32'h00317063, 10'h010, 3'd0}, // bgeu
    {32'h00312063, 10'h000, 3'd5}, // f3 010 branch
    {32'h008000EF, 10'h020, 3'd0}, // jal
    {32'h000100E7, 10'h040, 3'd0}, // jalr
    {32'h000110E7, 10'h000, 3'd5}, // jalr f3 001
    {32'h123450B7, 10'h080, 3'd0}, // lui
    {32'h12345097, 10'h100, 3'd0}, // auipc
    {32'h0FF0000F, 10'h200, 3'd0}, // fence
    {32'h0000100F, 10'h000, 3'd3}, // fence.i
    {32'h0000200F, 10'h000, 3'd5}, // misc f3 010
    {32'h00000073, 10'h000, 3'd1}, // ecall
    {32'h00100073, 10'h000, 3'd2}, // ebreak
    {32'h300110F3, 10'h000, 3'd4}, // csrrw
    {32'h30200073, 10'h000, 3'd4}, // mret
    {32'h10500073, 10'h000, 3'd4}, // wfi
    {32'h00000001, 10'h000, 3'd5}, // compressed nop
    {32'h00000000, 10'h000, 3'd5}, // all zero
    {32'h0000007F, 10'h000, 3'd5}, // unknown opcode
    {32'h0000002F, 10'h000, 3'd5}, // atomic opcode
    {32'hFFFFFFFF, 10'h000, 3'd5}  // all ones
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int i, input logic [9:0] c, input logic [2:0] z);
    if (i < 13) return "R2";
    case (z)
      3'd1, 3'd2: return "R5";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return (c == 10'h200) ? "R3" : "R1";
    endcase
  endfunction

  task automatic present(input logic [31:0] w, input logic [31:0] pc, input logic v);
    @(negedge clk);
    in_instr = w;
    in_pc    = pc;
    in_valid = v;
  endtask

  task automatic chk_cap(input string req, input logic h, input logic [31:0] pc,
                         input logic [31:0] w, input logic [2:0] z);
    chk(req, "halt", {31'd0, halt}, {31'd0, h});
    chk("R10", "stall", {31'd0, stall}, {31'd0, h});
    chk(req, "halt_pc", halt_pc, pc);
    chk(req, "halt_instr", halt_instr, w);
    chk(req, "halt_cause", {29'd0, halt_cause}, {29'd0, z});
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 chk_cap("R12", 1'b0, 32'h0, 32'h0, 3'd0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      present(VEC[i][44:13], 32'h1000 + 32'(i) * 4, 1'b0);
      #1;
      chk(tag_of(i, VEC[i][12:3], VEC[i][2:0]), $sformatf("class[%0d]", i),
          {22'd0, dec_class}, {22'd0, VEC[i][12:3]});
      chk(tag_of(i, VEC[i][12:3], VEC[i][2:0]), $sformatf("cause[%0d]", i),
          {29'd0, dec_cause}, {29'd0, VEC[i][2:0]});
      if (VEC[i][2:0] == 3'd0) begin
        in_valid = 1'b1;               // legal word with valid: must not halt (R11, R3)
        @(posedge clk); #1;
        chk("R11", $sformatf("no halt on legal[%0d]", i), {31'd0, halt}, 32'd0);
      end
    end

    // R11: illegal word without valid
    present(32'h0000_0073, 32'h2000, 1'b0);
    repeat (2) @(posedge clk);
    #1 chk("R11", "no halt when invalid", {31'd0, halt}, 32'd0);

    // R8 / R4: fence.i with valid halts next edge
    present(32'h0000_100F, 32'h8000_0040, 1'b1);
    @(posedge clk); #1;
    chk_cap("R8", 1'b1, 32'h8000_0040, 32'h0000_100F, 3'd3);

    // R9: later illegal words do not overwrite
    present(32'h0010_0073, 32'h8000_0044, 1'b1);
    repeat (3) @(posedge clk);
    #1 chk_cap("R9", 1'b1, 32'h8000_0040, 32'h0000_100F, 3'd3);

    // R12: reset clears
    @(negedge clk) begin rst = 1'b1; in_valid = 1'b0; end
    @(posedge clk); #1;
    chk_cap("R12", 1'b0, 32'h0, 32'h0, 3'd0);
    @(negedge clk) rst = 1'b0;

    // R5: ecall after reset halts with cause 1
    present(32'h0000_0073, 32'h0000_0100, 1'b1);
    @(posedge clk); #1;
    chk_cap("R5", 1'b1, 32'h0000_0100, 32'h0000_0073, 3'd1);
    @(negedge clk) in_valid = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule